// File: doc/BRIEF.md
# Branch Condition and Loop-Decrement Unit

This unit makes the taken/not-taken decision for conditional branches. It has three families. Flag-test branches look at one bit of the flag register, picked by its index. Counting-loop branches test a single register against zero and, when they fall through, write back that register minus one. Two-register branches compare two operands as unsigned numbers. The register-testing forms also produce fresh carry, zero and negative flags. The target address and the program counter stay with the surrounding control logic.

Operands are sampled on a clock edge while `en_i` is high. All results appear on registered outputs one cycle later. When `en_i` is low, the next cycle shows no taken branch, no register write and no flag write.

Top module: `bcu_top`

## Requirements
- R1: While `rst_ni` is low, `taken_o`, `wr_en_o` and `flags_we_o` are 0, and `wr_data_o` and `flags_o` are 0.
- R2: Results appear on the outputs one clock after the edge that samples `en_i` high. If `en_i` was low at that edge, `taken_o`, `wr_en_o` and `flags_we_o` are 0 in the next cycle.
- R3: Opcode 0 (branch-on-clear) is taken when `flags_i[flag_sel_i]` is 0. Opcode 1 (branch-on-set) is taken when that bit is 1.
- R4: Opcodes 0 and 1 never assert `flags_we_o` or `wr_en_o`.
- R5: Opcode 2 (zero-loop) is taken when `ra_i` is 0. Otherwise it is not taken and writes `ra_i`-1.
- R6: Opcode 3 (nonzero-loop) is taken when `ra_i` is nonzero. Otherwise it is not taken and writes `ra_i`-1, which wraps to all ones.
- R7: Opcode 4 is taken when `ra_i == rb_i`. Opcode 5 is taken when they differ.
- R8: Opcode 6 is taken when `ra_i > rb_i`. Opcode 7 is taken when `ra_i >= rb_i`. Both compares are unsigned.
- R9: For opcodes 2 to 7, `flags_we_o` is 1 and `flags_o` = {N,Z,C} (bit 2 = N, bit 1 = Z, bit 0 = C) describes the difference `ra_i - b`. Here b is `rb_i` for opcodes 4 to 7 and 0 for opcodes 2 and 3. C is the borrow out, Z means the difference is zero, and N is the difference's MSB.
- R10: `wr_en_o` is 1 only for opcodes 2 and 3, and only when that branch is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Evaluate a branch this cycle |
| op_i | input | 3 | Branch opcode (0..7) |
| flag_sel_i | input | $clog2(FLAG_W) | Index of the flag bit to test |
| flags_i | input | FLAG_W | Current flag register |
| ra_i | input | DATA_W | First register operand |
| rb_i | input | DATA_W | Second register operand |
| taken_o | output | 1 | Branch taken |
| wr_en_o | output | 1 | Write decremented value back |
| wr_data_o | output | DATA_W | Decremented register value |
| flags_we_o | output | 1 | Update C, Z, N |
| flags_o | output | 3 | {N, Z, C} |

## Verification
The bench drives operand pairs where signed and unsigned ordering disagree, such as 200 against 3. A design that compared as signed would reject the greater-than branch in that case. It drives the nonzero-loop with a zero register, so the write must wrap to all ones, and it drives the zero-loop with 0x80, so the written value must show the MSB leaving. Flag tests use a high bit index and a pattern where neighbouring bits differ, which catches a swapped or off-by-one bit select. It also checks that flag tests leave flags unwritten, and that a fall-through write never comes together with a taken branch.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [2:0] {
    OP_FCLR = 3'd0,
    OP_FSET = 3'd1,
    OP_ZLP  = 3'd2,
    OP_NZLP = 3'd3,
    OP_EQ   = 3'd4,
    OP_NE   = 3'd5,
    OP_GT   = 3'd6,
    OP_GE   = 3'd7
  } bcu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } bcu_flags_t;

  function automatic logic is_loop(bcu_op_e op);
    return (op == OP_ZLP) || (op == OP_NZLP);
  endfunction

  function automatic logic is_ftest(bcu_op_e op);
    return (op == OP_FCLR) || (op == OP_FSET);
  endfunction
endpackage

// File: rtl/bcu_flag_pick.sv
module bcu_flag_pick #(
  parameter int FLAG_W = 8,
  localparam int SEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              bit_o
);
  logic [(1<<SEL_W)-1:0] padded;

  // unused indices read as 0
  generate
    if ((1 << SEL_W) > FLAG_W) begin : g_pad
      assign padded = {{((1<<SEL_W)-FLAG_W){1'b0}}, flags_i};
    end else begin : g_nopad
      assign padded = flags_i;
    end
  endgenerate

  assign bit_o = padded[sel_i];
endmodule

// File: rtl/bcu_compare.sv
module bcu_compare
  import bcu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              use_b_i,
  output bcu_flags_t        flags_o,
  output logic [DATA_W-1:0] dec_o
);
  logic [DATA_W-1:0] rhs;
  logic [DATA_W:0]   diff;

  assign rhs  = use_b_i ? b_i : '0;
  assign diff = {1'b0, a_i} - {1'b0, rhs};

  always_comb begin
    flags_o.c = diff[DATA_W];
    flags_o.z = (diff[DATA_W-1:0] == '0);
    flags_o.n = diff[DATA_W-1];
  end

  assign dec_o = a_i - DATA_W'(1);
endmodule

// File: rtl/bcu_decide.sv
module bcu_decide
  import bcu_pkg::*;
(
  input  bcu_op_e    op_i,
  input  logic       flag_bit_i,
  input  bcu_flags_t cmp_i,
  output logic       taken_o,
  output logic       wr_en_o,
  output logic       flags_we_o
);
  always_comb begin
    unique case (op_i)
      OP_FCLR: taken_o = ~flag_bit_i;
      OP_FSET: taken_o =  flag_bit_i;
      OP_ZLP:  taken_o =  cmp_i.z;
      OP_NZLP: taken_o = ~cmp_i.z;
      OP_EQ:   taken_o =  cmp_i.z;
      OP_NE:   taken_o = ~cmp_i.z;
      OP_GT:   taken_o = ~cmp_i.c & ~cmp_i.z;
      OP_GE:   taken_o = ~cmp_i.c;
      default: taken_o = 1'b0;
    endcase
    wr_en_o    = is_loop(op_i) & ~taken_o;
    flags_we_o = ~is_ftest(op_i);
  end
endmodule

// File: rtl/bcu_top.sv
module bcu_top
  import bcu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  localparam int SEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        op_i,
  input  logic [SEL_W-1:0]  flag_sel_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DATA_W-1:0] ra_i,
  input  logic [DATA_W-1:0] rb_i,
  output logic              taken_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              flags_we_o,
  output logic [2:0]        flags_o
);
  bcu_op_e           op;
  logic              flag_bit;
  bcu_flags_t        cmp;
  logic [DATA_W-1:0] dec;
  logic              taken_d, wr_en_d, fwe_d;

  assign op = bcu_op_e'(op_i);

  bcu_flag_pick #(.FLAG_W(FLAG_W)) u_pick (
    .flags_i (flags_i),
    .sel_i   (flag_sel_i),
    .bit_o   (flag_bit)
  );

  bcu_compare #(.DATA_W(DATA_W)) u_cmp (
    .a_i     (ra_i),
    .b_i     (rb_i),
    .use_b_i (~is_loop(op)),
    .flags_o (cmp),
    .dec_o   (dec)
  );

  bcu_decide u_dec (
    .op_i       (op),
    .flag_bit_i (flag_bit),
    .cmp_i      (cmp),
    .taken_o    (taken_d),
    .wr_en_o    (wr_en_d),
    .flags_we_o (fwe_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o    <= 1'b0;
      wr_en_o    <= 1'b0;
      flags_we_o <= 1'b0;
      wr_data_o  <= '0;
      flags_o    <= '0;
    end else begin
      taken_o    <= en_i & taken_d;
      wr_en_o    <= en_i & wr_en_d;
      flags_we_o <= en_i & fwe_d;
      wr_data_o  <= dec;
      flags_o    <= cmp;
    end
  end
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  localparam int SEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [2:0]        op_i,
  input logic [SEL_W-1:0]  flag_sel_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [DATA_W-1:0] ra_i,
  input logic [DATA_W-1:0] rb_i,
  input logic              taken_o,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              flags_we_o,
  input logic [2:0]        flags_o
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!taken_o && !wr_en_o && !flags_we_o));

  assert_ftest_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i[2:1] == 2'b00) |=> (!flags_we_o && !wr_en_o));

  assert_write_not_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !taken_o);

  assert_write_only_loop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i[2:1] != 2'b01) |=> !wr_en_o);

  assert_dec_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i[2:1] == 2'b01) |=> (wr_data_o == DATA_W'($past(ra_i) - DATA_W'(1))));

  assert_eq_follows_z_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 3'd4) |=> (taken_o == flags_o[1]));

  assert_ge_follows_c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 3'd7) |=> (taken_o == !flags_o[0]));

  assert_loop_no_borrow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i[2:1] == 2'b01) |=> (flags_we_o && !flags_o[0]));
endmodule

bind bcu_top bcu_checker #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i),
  .flag_sel_i(flag_sel_i), .flags_i(flags_i), .ra_i(ra_i), .rb_i(rb_i),
  .taken_o(taken_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
  .flags_we_o(flags_we_o), .flags_o(flags_o)
);

// File: tb/tb_bcu_top.sv
module tb_bcu_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [2:0] flag_sel_i = '0;
  logic [7:0] flags_i = '0;
  logic [7:0] ra_i = '0;
  logic [7:0] rb_i = '0;
  logic       taken_o, wr_en_o, flags_we_o;
  logic [7:0] wr_data_o;
  logic [2:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  bcu_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i),
    .flag_sel_i(flag_sel_i), .flags_i(flags_i), .ra_i(ra_i), .rb_i(rb_i),
    .taken_o(taken_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .flags_we_o(flags_we_o), .flags_o(flags_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, sampled at posedge, checked at next negedge
  task automatic run(string req, logic [2:0] op, logic [2:0] sel, logic [7:0] fl,
                     logic [7:0] a, logic [7:0] b, logic e_tk, logic e_we,
                     logic [7:0] e_dat, logic e_fwe, logic [2:0] e_fl);
    @(negedge clk_i);
    en_i = 1'b1; op_i = op; flag_sel_i = sel; flags_i = fl; ra_i = a; rb_i = b;
    @(negedge clk_i);
    en_i = 1'b0;
    chk(req, "taken", int'(taken_o), int'(e_tk));
    chk(req, "wr_en", int'(wr_en_o), int'(e_we));
    if (e_we) chk(req, "wr_data", int'(wr_data_o), int'(e_dat));
    chk(req, "flags_we", int'(flags_we_o), int'(e_fwe));
    if (e_fwe) chk(req, "flags", int'(flags_o), int'(e_fl));
  endtask

  task automatic t_reset();
    chk("R1", "taken", int'(taken_o), 0);
    chk("R1", "wr_en", int'(wr_en_o), 0);
    chk("R1", "flags_we", int'(flags_we_o), 0);
    chk("R1", "wr_data", int'(wr_data_o), 0);
    chk("R1", "flags", int'(flags_o), 0);
  endtask

  task automatic t_flag_test();
    // R3 / R4: pattern 1010_0101
    run("R3", 3'd0, 3'd0, 8'hA5, 8'h00, 8'h00, 0, 0, 0, 0, 0);
    run("R3", 3'd1, 3'd0, 8'hA5, 8'h00, 8'h00, 1, 0, 0, 0, 0);
    run("R3", 3'd0, 3'd1, 8'hA5, 8'h00, 8'h00, 1, 0, 0, 0, 0);
    run("R4", 3'd1, 3'd7, 8'hA5, 8'h00, 8'h00, 1, 0, 0, 0, 0);
    run("R4", 3'd1, 3'd6, 8'hA5, 8'h00, 8'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic t_zero_loop();
    run("R5", 3'd2, 3'd0, 8'h00, 8'h00, 8'h33, 1, 0, 0, 1, 3'b010);
    run("R5", 3'd2, 3'd0, 8'h00, 8'h05, 8'h33, 0, 1, 8'h04, 1, 3'b000);
    run("R9", 3'd2, 3'd0, 8'h00, 8'h80, 8'hFF, 0, 1, 8'h7F, 1, 3'b100);
  endtask

  task automatic t_nonzero_loop();
    run("R6", 3'd3, 3'd0, 8'h00, 8'h03, 8'h00, 1, 0, 0, 1, 3'b000);
    run("R6", 3'd3, 3'd0, 8'h00, 8'h00, 8'h09, 0, 1, 8'hFF, 1, 3'b010);
  endtask

  task automatic t_compare();
    // equal operands
    run("R7", 3'd4, 3'd0, 8'h00, 8'h05, 8'h05, 1, 0, 0, 1, 3'b010);
    run("R7", 3'd5, 3'd0, 8'h00, 8'h05, 8'h05, 0, 0, 0, 1, 3'b010);
    run("R8", 3'd6, 3'd0, 8'h00, 8'h05, 8'h05, 0, 0, 0, 1, 3'b010);
    run("R8", 3'd7, 3'd0, 8'h00, 8'h05, 8'h05, 1, 0, 0, 1, 3'b010);
    // 3 - 200 = 0x3B with borrow
    run("R9", 3'd6, 3'd0, 8'h00, 8'd3, 8'd200, 0, 0, 0, 1, 3'b001);
    run("R8", 3'd7, 3'd0, 8'h00, 8'd3, 8'd200, 0, 0, 0, 1, 3'b001);
    run("R7", 3'd5, 3'd0, 8'h00, 8'd3, 8'd200, 1, 0, 0, 1, 3'b001);
    // 200 - 3 = 0xC5, unsigned greater
    run("R8", 3'd6, 3'd0, 8'h00, 8'd200, 8'd3, 1, 0, 0, 1, 3'b100);
    run("R8", 3'd7, 3'd0, 8'h00, 8'd200, 8'd3, 1, 0, 0, 1, 3'b100);
    run("R10", 3'd4, 3'd0, 8'h00, 8'd200, 8'd3, 0, 0, 0, 1, 3'b100);
  endtask

  task automatic t_idle();
    run("R2", 3'd1, 3'd2, 8'h04, 8'h00, 8'h00, 1, 0, 0, 0, 0);
    @(negedge clk_i);
    en_i = 1'b0; op_i = 3'd3; ra_i = 8'h00;
    @(negedge clk_i);
    chk("R2", "idle taken", int'(taken_o), 0);
    chk("R2", "idle wr_en", int'(wr_en_o), 0);
    chk("R2", "idle flags_we", int'(flags_we_o), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_flag_test();
    t_zero_loop();
    t_nonzero_loop();
    t_compare();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule